// File: doc/BRIEF.md
# Trace Packet Pipeline Bus Replayer

This block turns a compressed stream of execution trace packets, produced by an instruction-level processor model, into a cycle-by-cycle picture of a three-stage fetch/decode/execute pipeline. It drives a Harvard pair of buses: an instruction bus with a fetch address and read word, and a data bus with address, read data, write data and transfer qualifiers. It also exposes the contents of the three pipeline stages. No memory is read. Every word on the buses comes from the packets.

Packets arrive on a valid/ready stream. Each packet carries a kind code, an address field, three data words and a few attributes. The main saving is on sequential code. Once the pipeline is full, an instruction packet whose program counter follows on from the previous one contributes only its pc and the word at pc+8. The stage contents shift by one and the fetch address advances by one word. The two other words in the packet are not used.

Any other program counter is treated as a change of flow. This includes the first instruction after reset. The pipeline is flushed and refilled over three fetch beats from the full packet. Conditional instructions, single and multiple loads, and single and multiple stores are each followed by their own trailing packets in a fixed order. A packet that breaks this order is dropped and sets a sticky error flag.

Top module: `pipe_trace_replayer`

## Requirements
- R1: After reset `ibus_addr` is 0, `pipe_valid` is 0, `pkt_ready` is 1, `seq_err` is 0 and `dbus_trans` is 0.
- R2: An instruction packet (kind 0) whose pc is not exactly 4 above the previous instruction packet's pc counts as a change of flow. The first instruction packet after reset always counts as one. The cycle after acceptance shows `flush`=1, `pipe_valid`=0, a fetch beat at pc with word w0, and `pkt_ready`=0. The next cycle shows a fetch beat at pc+4 with w1, and `pkt_ready` stays 0. The third cycle shows a fetch beat at pc+8 with w2 and `pkt_ready`=1. In that third cycle the stages hold execute=w0, decode=w1, fetch=w2, `ex_pc`=pc and `pipe_valid`=1.
- R3: An instruction packet whose pc is the previous pc+4 produces one fetch beat at pc+8 carrying w2, with no flush. The stages shift: execute takes the old decode word, decode takes the old fetch word, fetch takes w2, and `ex_pc`=pc. Words w0 and w1 are ignored.
- R4: A status packet (kind 1) sets `cond_flags` to the top four bits of w0, bits 31 to 28. It produces no fetch beat and no data transfer.
- R5: A load address packet (kind 2) produces one cycle with `dbus_trans`=1 and `dbus_write`=0, `dbus_addr` set to the packet address, and `ibus_addr` set to `ex_pc`+12 with no fetch beat. A load data packet (kind 3) sets `dbus_rdata` to w0.
- R6: A store packet (kind 4) produces one cycle with `dbus_trans`=1, `dbus_write`=1 and `dbus_addr` set to the packet address, with `pkt_ready`=0. In the following cycle `dbus_wdata` becomes w0 and `pkt_ready` returns to 1.
- R7: The packets trailing an instruction come in a fixed order. If `pkt_cond` is set, one status packet comes first. Then come `pkt_nacc` accesses. For `pkt_store`=0 these are load address/load data pairs, 2n packets in all. For `pkt_store`=1 they are n store packets. After that the next instruction packet is expected.
- R8: A packet whose kind differs from the expected one, including the unused codes 5 to 7, is consumed without effect on any bus or stage output. It sets `seq_err`, and `seq_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet can be taken this cycle |
| pkt_kind | input | 3 | 0 instr, 1 status, 2 load addr, 3 load data, 4 store |
| pkt_addr | input | AW | pc or data address |
| pkt_w0 | input | DW | Word at pc / status / load or store data |
| pkt_w1 | input | DW | Word at pc+4 |
| pkt_w2 | input | DW | Word at pc+8 |
| pkt_cond | input | 1 | Instruction is conditional |
| pkt_store | input | 1 | Accesses are stores |
| pkt_nacc | input | CW | Number of data accesses |
| ibus_addr | output | AW | Instruction bus address |
| ibus_rdata | output | DW | Instruction bus read word |
| ibus_fetch | output | 1 | Fetch beat this cycle |
| dbus_addr | output | AW | Data bus address |
| dbus_rdata | output | DW | Data bus read word |
| dbus_wdata | output | DW | Data bus write word |
| dbus_trans | output | 1 | Data address phase this cycle |
| dbus_write | output | 1 | Data transfer is a write |
| cond_flags | output | 4 | Last status flags |
| flush | output | 1 | Pipeline flushed this cycle |
| pipe_valid | output | 1 | Stage view is filled |
| ex_pc | output | AW | pc of instruction in execute |
| ex_instr | output | DW | Execute stage word |
| de_instr | output | DW | Decode stage word |
| fe_instr | output | DW | Fetch stage word |
| seq_err | output | 1 | Sticky packet order error |

## Verification
A load address packet drives both buses in the same cycle. The data bus shows its address phase, and the instruction bus moves on to the execute pc plus 12. The bench triggers this with loads straight after a refill and after sequential runs, and with multiple loads where the step repeats. In each such cycle it compares `dbus_addr`, `dbus_write`, `ibus_addr` and `ibus_fetch` together against the pc its own model holds for the execute stage. A dropped out-of-order packet is also judged in the cycle it is consumed: no bus moves while `seq_err` rises.

// File: rtl/pipe_trace_replayer.sv
module pipe_trace_replayer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_valid,
  output logic          pkt_ready,
  input  logic [2:0]    pkt_kind,
  input  logic [AW-1:0] pkt_addr,
  input  logic [DW-1:0] pkt_w0,
  input  logic [DW-1:0] pkt_w1,
  input  logic [DW-1:0] pkt_w2,
  input  logic          pkt_cond,
  input  logic          pkt_store,
  input  logic [CW-1:0] pkt_nacc,
  output logic [AW-1:0] ibus_addr,
  output logic [DW-1:0] ibus_rdata,
  output logic          ibus_fetch,
  output logic [AW-1:0] dbus_addr,
  output logic [DW-1:0] dbus_rdata,
  output logic [DW-1:0] dbus_wdata,
  output logic          dbus_trans,
  output logic          dbus_write,
  output logic [3:0]    cond_flags,
  output logic          flush,
  output logic          pipe_valid,
  output logic [AW-1:0] ex_pc,
  output logic [DW-1:0] ex_instr,
  output logic [DW-1:0] de_instr,
  output logic [DW-1:0] fe_instr,
  output logic          seq_err
);

  localparam logic [AW-1:0] STEP1 = AW'(DW / 8);
  localparam logic [AW-1:0] STEP2 = AW'(2 * (DW / 8));
  localparam logic [AW-1:0] STEP3 = AW'(3 * (DW / 8));

  localparam logic [2:0] K_INSTR  = 3'd0;
  localparam logic [2:0] K_STAT   = 3'd1;
  localparam logic [2:0] K_LDADDR = 3'd2;
  localparam logic [2:0] K_LDDATA = 3'd3;
  localparam logic [2:0] K_STORE  = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_RF1, PH_RF2, PH_ST2} ph_t;

  ph_t           ph;
  logic [AW-1:0] buf_pc;
  logic [DW-1:0] buf_w0, buf_w1, buf_w2, st_data;
  logic [AW-1:0] exp_pc;
  logic          exp_ok, need_stat, acc_st, ld_dat;
  logic [CW-1:0] acc_left;
  logic [2:0]    want;
  logic          accept, good, bad, is_seq;

  assign pkt_ready = (ph == PH_IDLE);
  assign accept    = pkt_valid && pkt_ready;
  assign good      = accept && (pkt_kind == want);
  assign bad       = accept && (pkt_kind != want);
  assign is_seq    = exp_ok && (pkt_addr == exp_pc);

  always_comb begin
    if (need_stat)           want = K_STAT;
    else if (acc_left != '0) want = acc_st ? K_STORE : (ld_dat ? K_LDDATA : K_LDADDR);
    else                     want = K_INSTR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      buf_pc     <= '0;
      buf_w0     <= '0;
      buf_w1     <= '0;
      buf_w2     <= '0;
      st_data    <= '0;
      exp_pc     <= '0;
      exp_ok     <= 1'b0;
      need_stat  <= 1'b0;
      acc_st     <= 1'b0;
      ld_dat     <= 1'b0;
      acc_left   <= '0;
      ibus_addr  <= '0;
      ibus_rdata <= '0;
      ibus_fetch <= 1'b0;
      dbus_addr  <= '0;
      dbus_rdata <= '0;
      dbus_wdata <= '0;
      dbus_trans <= 1'b0;
      dbus_write <= 1'b0;
      cond_flags <= '0;
      flush      <= 1'b0;
      pipe_valid <= 1'b0;
      ex_pc      <= '0;
      ex_instr   <= '0;
      de_instr   <= '0;
      fe_instr   <= '0;
      seq_err    <= 1'b0;
    end else begin
      ibus_fetch <= 1'b0;
      flush      <= 1'b0;
      dbus_trans <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (bad) seq_err <= 1'b1;
          if (good) begin
            unique case (pkt_kind)
              K_INSTR: begin
                exp_pc     <= pkt_addr + STEP1;
                exp_ok     <= 1'b1;
                need_stat  <= pkt_cond;
                acc_left   <= pkt_nacc;
                acc_st     <= pkt_store;
                ld_dat     <= 1'b0;
                ibus_fetch <= 1'b1;
                if (is_seq) begin
                  ibus_addr  <= pkt_addr + STEP2;
                  ibus_rdata <= pkt_w2;
                  ex_instr   <= de_instr;
                  de_instr   <= fe_instr;
                  fe_instr   <= pkt_w2;
                  ex_pc      <= pkt_addr;
                end else begin
                  flush      <= 1'b1;
                  pipe_valid <= 1'b0;
                  ibus_addr  <= pkt_addr;
                  ibus_rdata <= pkt_w0;
                  buf_pc     <= pkt_addr;
                  buf_w0     <= pkt_w0;
                  buf_w1     <= pkt_w1;
                  buf_w2     <= pkt_w2;
                  ph         <= PH_RF1;
                end
              end
              K_STAT: begin
                cond_flags <= pkt_w0[DW-1 -: 4];
                need_stat  <= 1'b0;
              end
              K_LDADDR: begin
                dbus_addr  <= pkt_addr;
                dbus_trans <= 1'b1;
                dbus_write <= 1'b0;
                ibus_addr  <= ex_pc + STEP3;
                ld_dat     <= 1'b1;
              end
              K_LDDATA: begin
                dbus_rdata <= pkt_w0;
                ld_dat     <= 1'b0;
                acc_left   <= acc_left - 1'b1;
              end
              K_STORE: begin
                dbus_addr  <= pkt_addr;
                dbus_trans <= 1'b1;
                dbus_write <= 1'b1;
                st_data    <= pkt_w0;
                acc_left   <= acc_left - 1'b1;
                ph         <= PH_ST2;
              end
              default: ;
            endcase
          end
        end
        PH_RF1: begin
          ibus_fetch <= 1'b1;
          ibus_addr  <= buf_pc + STEP1;
          ibus_rdata <= buf_w1;
          ph         <= PH_RF2;
        end
        PH_RF2: begin
          ibus_fetch <= 1'b1;
          ibus_addr  <= buf_pc + STEP2;
          ibus_rdata <= buf_w2;
          ex_instr   <= buf_w0;
          de_instr   <= buf_w1;
          fe_instr   <= buf_w2;
          ex_pc      <= buf_pc;
          pipe_valid <= 1'b1;
          ph         <= PH_IDLE;
        end
        PH_ST2: begin
          dbus_wdata <= st_data;
          ph         <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_REFILL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!pkt_ready && !pipe_valid && ibus_fetch)); // R2

  AST_FETCH_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_fetch && !flush && $past(ibus_fetch)) |-> (ibus_addr == $past(ibus_addr) + STEP1)); // R3

  AST_LOAD_NEXT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_trans && !dbus_write) |-> (ibus_addr == ex_pc + STEP3 && !ibus_fetch)); // R5

  AST_STORE_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_trans && dbus_write) |-> !pkt_ready); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_err) |-> seq_err); // R8

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> (!ibus_fetch && !dbus_trans && !flush)); // R8

endmodule

// File: tb/pipe_trace_replayer_tb.sv
module pipe_trace_replayer_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [2:0]  pkt_kind = '0;
  logic [31:0] pkt_addr = '0, pkt_w0 = '0, pkt_w1 = '0, pkt_w2 = '0;
  logic        pkt_cond = 1'b0, pkt_store = 1'b0;
  logic [3:0]  pkt_nacc = '0;
  logic [31:0] ibus_addr, ibus_rdata, dbus_addr, dbus_rdata, dbus_wdata;
  logic        ibus_fetch, dbus_trans, dbus_write, flush, pipe_valid, seq_err;
  logic [3:0]  cond_flags;
  logic [31:0] ex_pc, ex_instr, de_instr, fe_instr;

  always #(CLK_NS / 2) clk = ~clk;

  pipe_trace_replayer u_dut (
    .clk, .rst_n, .pkt_valid, .pkt_ready, .pkt_kind, .pkt_addr,
    .pkt_w0, .pkt_w1, .pkt_w2, .pkt_cond, .pkt_store, .pkt_nacc,
    .ibus_addr, .ibus_rdata, .ibus_fetch, .dbus_addr, .dbus_rdata,
    .dbus_wdata, .dbus_trans, .dbus_write, .cond_flags, .flush,
    .pipe_valid, .ex_pc, .ex_instr, .de_instr, .fe_instr, .seq_err
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_exp, m_ex, m_de, m_fe, m_expc, m_rdata;
  bit          m_ok;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [31:0] a, input logic [31:0] w0,
                       input logic [31:0] w1, input logic [31:0] w2,
                       input bit c, input bit s, input logic [3:0] n);
    @(negedge clk);
    pkt_kind = k; pkt_addr = a; pkt_w0 = w0; pkt_w1 = w1; pkt_w2 = w2;
    pkt_cond = c; pkt_store = s; pkt_nacc = n; pkt_valid = 1'b1;
    while (!pkt_ready) @(negedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic instr(input logic [31:0] pc, input bit c, input bit s, input logic [3:0] n);
    logic [31:0] w0, w1, w2;
    w0 = $urandom; w1 = $urandom; w2 = $urandom;
    if (!m_ok || pc != m_exp) begin
      drive(3'd0, pc, w0, w1, w2, c, s, n);
      chk("R2 flush", {31'd0, flush}, 32'd1);
      chk("R2 beat0 addr", ibus_addr, pc);
      chk("R2 beat0 word", ibus_rdata, w0);
      chk("R2 beat0 ready", {31'd0, pkt_ready}, 32'd0);
      chk("R2 beat0 pipe_valid", {31'd0, pipe_valid}, 32'd0);
      @(negedge clk);
      chk("R2 beat1 addr", ibus_addr, pc + 32'd4);
      chk("R2 beat1 word", ibus_rdata, w1);
      chk("R2 beat1 ready", {31'd0, pkt_ready}, 32'd0);
      @(negedge clk);
      chk("R2 beat2 addr", ibus_addr, pc + 32'd8);
      chk("R2 beat2 word", ibus_rdata, w2);
      chk("R2 ready back", {31'd0, pkt_ready}, 32'd1);
      chk("R2 ex", ex_instr, w0);
      chk("R2 de", de_instr, w1);
      chk("R2 fe", fe_instr, w2);
      chk("R2 ex_pc", ex_pc, pc);
      chk("R2 pipe_valid", {31'd0, pipe_valid}, 32'd1);
      m_ex = w0; m_de = w1; m_fe = w2;
    end else begin
      drive(3'd0, pc, w0, w1, w2, c, s, n);
      chk("R3 no flush", {31'd0, flush}, 32'd0);
      chk("R3 fetch", {31'd0, ibus_fetch}, 32'd1);
      chk("R3 addr", ibus_addr, pc + 32'd8);
      chk("R3 word", ibus_rdata, w2);
      chk("R3 ex ignores w0", ex_instr, m_de);
      chk("R3 de ignores w1", de_instr, m_fe);
      chk("R3 fe", fe_instr, w2);
      chk("R3 ex_pc", ex_pc, pc);
      m_ex = m_de; m_de = m_fe; m_fe = w2;
    end
    m_expc = pc; m_exp = pc + 32'd4; m_ok = 1'b1;
  endtask

  task automatic status(input logic [31:0] w);
    drive(3'd1, 32'd0, w, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0);
    chk("R4 flags", {28'd0, cond_flags}, {28'd0, w[31:28]});
    chk("R4 no fetch", {31'd0, ibus_fetch}, 32'd0);
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] d);
    drive(3'd2, a, 32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0);
    chk("R5 daddr", dbus_addr, a);
    chk("R5 trans", {31'd0, dbus_trans}, 32'd1);
    chk("R5 read", {31'd0, dbus_write}, 32'd0);
    chk("R5 ibus pc+12", ibus_addr, m_expc + 32'd12);
    chk("R5 no fetch", {31'd0, ibus_fetch}, 32'd0);
    drive(3'd3, 32'd0, d, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0);
    chk("R5 rdata", dbus_rdata, d);
    m_rdata = d;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    drive(3'd4, a, d, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0);
    chk("R6 daddr", dbus_addr, a);
    chk("R6 trans write", {30'd0, dbus_trans, dbus_write}, 32'd3);
    chk("R6 stall", {31'd0, pkt_ready}, 32'd0);
    @(negedge clk);
    chk("R6 wdata", dbus_wdata, d);
    chk("R6 ready", {31'd0, pkt_ready}, 32'd1);
  endtask

  task automatic run_instr(input logic [31:0] pc, input bit c, input bit s, input logic [3:0] n);
    instr(pc, c, s, n);
    if (c) status($urandom);
    for (int i = 0; i < int'(n); i++) begin
      if (s) store($urandom & 32'hFFFF_FFFC, $urandom);
      else   load($urandom & 32'hFFFF_FFFC, $urandom);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    void'($urandom(32'h5EED_0042));
    m_ok = 1'b0; m_exp = '0; m_ex = '0; m_de = '0; m_fe = '0; m_expc = '0; m_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ibus_addr", ibus_addr, 32'd0);
    chk("R1 pipe_valid", {31'd0, pipe_valid}, 32'd0);
    chk("R1 ready", {31'd0, pkt_ready}, 32'd1);
    chk("R1 seq_err", {31'd0, seq_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {31'd0, dbus_trans}, 32'd0);

    run_instr(32'h0, 1'b0, 1'b0, 4'd0);
    run_instr(32'h4, 1'b0, 1'b0, 4'd1);
    run_instr(32'h8, 1'b1, 1'b0, 4'd0);
    run_instr(32'hC, 1'b0, 1'b1, 4'd1);
    run_instr(32'h10, 1'b1, 1'b0, 4'd3);   // R7 multiple load
    run_instr(32'h14, 1'b0, 1'b1, 4'd3);   // R7 multiple store
    run_instr(32'h0001_0000, 1'b0, 1'b0, 4'd2);
    run_instr(32'h0001_0004, 1'b1, 1'b1, 4'd2);

    pc = 32'h0001_0008;
    for (int i = 0; i < 300; i++) begin
      bit c, s;
      logic [3:0] n;
      if (($urandom % 8) == 0) pc = $urandom & 32'hFFFF_FFFC;
      c = (($urandom % 4) == 0);
      s = (($urandom % 2) == 0);
      n = (($urandom % 3) == 0) ? 4'($urandom % 4) : 4'd0;
      run_instr(pc, c, s, n);
      pc = pc + 32'd4;
    end

    drive(3'd3, 32'd0, 32'hDEAD_BEEF, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0);
    chk("R8 err set", {31'd0, seq_err}, 32'd1);
    chk("R8 no fetch", {31'd0, ibus_fetch}, 32'd0);
    chk("R8 no dtrans", {31'd0, dbus_trans}, 32'd0);
    chk("R8 rdata kept", dbus_rdata, m_rdata);
    chk("R8 stages kept", ex_instr, m_ex);
    drive(3'd7, 32'd0, 32'h1234_5678, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0);
    chk("R8 code7 dropped", {30'd0, ibus_fetch, dbus_trans}, 32'd0);
    chk("R8 code7 fe kept", fe_instr, m_fe);
    run_instr(pc, 1'b0, 1'b0, 4'd1);
    chk("R8 sticky", {31'd0, seq_err}, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule